// File: doc/BRIEF.md
# Word-to-Byte DMA Funnel

This block connects a 32-bit memory-side data path, owned by a bus master, to an 8-bit peripheral data port. Software sets a direction, a start byte address and a byte count, then pulses `start`. In the to-memory direction, bytes arrive from the peripheral through a request/acknowledge handshake. The block packs them little-endian into words, starting at the lane that the low address bits select. It queues each word in a 24-deep word FIFO together with its byte enables, and writes the words out at word-aligned addresses. In the from-memory direction, the block fetches words into the same FIFO. It then hands out their bytes one at a time, starting at the start-offset lane. It stops after exactly `count` bytes.

Programmed-I/O register accesses go around the FIFO and the packing logic. A PIO read returns the peripheral byte on the lowest lane with zeros above it. A PIO write sends the lowest lane of the write word to the peripheral. DMA requests are held off while either PIO strobe is active. When the count reaches zero and the FIFO has drained, the block raises `done`.

Top module: `funnel_dma`

## Requirements
- R1: While and after reset, `dreq`, `mem_rd_req`, `mem_wr_req` and `done` are low, `pio_rdata` is zero, and the internal byte count is zero, so no byte is requested.
- R2: With `dir`=0 (peripheral to memory), byte k of the transfer goes to byte address `start_addr`+k, packed little-endian. Each word write carries its word-aligned address and sets `mem_wr_be` bit i exactly for the lanes whose address lies in [start_addr, start_addr+count). A partial word is written when its top lane is filled or when the last byte arrives.
- R3: With `dir`=1 (memory to peripheral), the block fetches words from consecutive word-aligned addresses starting at `start_addr` rounded down. While `dreq` is high, `periph_wdata` shows the byte from address `start_addr`+k for the k-th byte. Lanes before the start offset and beyond the count are skipped.
- R4: The FIFO holds 24 words. In the to-memory direction with the memory side stalled, at most 96 bytes are accepted from an aligned start. In the from-memory direction with the peripheral stalled, at most 24 words are fetched ahead.
- R5: Exactly `count` bytes are exchanged on the narrow side, one per cycle with `dreq` and `dack` both high. `dreq` stays low when the count is zero or, in the from-memory direction, when the FIFO is empty.
- R6: `done` rises once the count is zero and the FIFO is empty, stays high until the next accepted `start`, and clears on that start. A transfer with count 0 completes without any request.
- R7: A `start` pulse while a transfer is in progress is ignored; the running transfer completes with its original count.
- R8: While `pio_rd` is high, `pio_rdata` = {24'b0, `periph_rdata`}; otherwise `pio_rdata` is zero.
- R9: While `pio_wr` is high, `periph_wdata` = `pio_wdata`[7:0]. While `pio_rd` or `pio_wr` is high, `dreq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| dir | input | 1 | 0 = peripheral to memory, 1 = memory to peripheral |
| start_addr | input | 32 | Start byte address |
| xfer_count | input | 16 | Number of bytes to transfer |
| done | output | 1 | Transfer complete, held until next start |
| dreq | output | 1 | Byte request to the peripheral |
| dack | input | 1 | Peripheral acknowledge; a byte moves when dreq and dack are both high |
| periph_rdata | input | 8 | Byte from the peripheral (DMA and PIO read) |
| periph_wdata | output | 8 | Byte to the peripheral (DMA or PIO write) |
| mem_addr | output | 32 | Word-aligned memory address of the current word |
| mem_rd_req | output | 1 | Word fetch request |
| mem_rd_ack | input | 1 | Fetch accepted; mem_rd_data valid |
| mem_rd_data | input | 32 | Fetched word |
| mem_wr_req | output | 1 | Word write request |
| mem_wr_ack | input | 1 | Write accepted |
| mem_wr_data | output | 32 | Word to write |
| mem_wr_be | output | 4 | Byte enables of the word to write |
| pio_rd | input | 1 | PIO read strobe |
| pio_wr | input | 1 | PIO write strobe |
| pio_wdata | input | 32 | PIO write word (lowest lane used) |
| pio_rdata | output | 32 | PIO read word |

## Verification
On every cycle the assertions check the following. The FIFO is never pushed when full or popped when empty. The byte count drops by one for each narrow-side handshake. Every word write has at least one byte enable set. `done` excludes every request. PIO strobes exclude `dreq`. Other behaviour needs whole scenarios, which only the bench's transfers can show: lane placement and byte enables for odd offsets and lengths, byte order on unpacking, the 96-byte and 24-word fill limits under stalls, and an ignored restart.

// File: rtl/funnel_pkg.sv
package funnel_pkg;
   typedef enum logic {
      DIR_TO_MEM   = 1'b0,
      DIR_FROM_MEM = 1'b1
   } funnel_dir_e;
endpackage

// File: rtl/funnel_fifo.sv
module funnel_fifo #(
   parameter int W     = 36,
   parameter int DEPTH = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [W-1:0]     store [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_nx, rp_nx;
   logic [LVL_W-1:0] level;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == LAST) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == LAST) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign full  = (level == LVL_W'(DEPTH));
   assign empty = (level == '0);
   assign head  = store[rp];

   always_ff @(posedge clk) begin
      if (push) store[wp] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         if (push && !pop)      level <= level + 1'b1;
         else if (pop && !push) level <= level - 1'b1;
      end
   end

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/funnel_narrow.sv
module funnel_narrow
   import funnel_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 16,
   localparam int BYTES  = WORD_W / 8,
   localparam int LANE_W = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  funnel_dir_e       dir,
   input  logic [LANE_W-1:0] off,
   input  logic [CNT_W-1:0]  count_in,
   input  logic              pio_busy,
   input  logic              dack,
   input  logic [7:0]        byte_in,
   input  logic              fifo_full,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] head_data,
   output logic              push,
   output logic [WORD_W-1:0] push_data,
   output logic [BYTES-1:0]  push_be,
   output logic              pop,
   output logic              dreq,
   output logic [7:0]        byte_out,
   output logic              cnt_zero
);
   localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(BYTES - 1);

   logic [CNT_W-1:0]  cnt;
   logic [LANE_W-1:0] lane;
   logic [WORD_W-1:0] pk_data;
   logic [BYTES-1:0]  pk_be;
   logic              take, wrap;

   assign cnt_zero = (cnt == '0);
   assign dreq = !cnt_zero && !pio_busy &&
                 ((dir == DIR_TO_MEM) ? !fifo_full : !fifo_empty);
   assign take = dreq && dack;
   assign wrap = (lane == TOP_LANE) || (cnt == CNT_W'(1));
   assign push = take && wrap && (dir == DIR_TO_MEM);
   assign pop  = take && wrap && (dir == DIR_FROM_MEM);
   assign byte_out = head_data[{lane, 3'b000} +: 8];

   always_comb begin
      push_data = pk_data;
      push_data[{lane, 3'b000} +: 8] = byte_in;
      push_be = pk_be;
      push_be[lane] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         lane    <= '0;
         pk_data <= '0;
         pk_be   <= '0;
      end else if (load) begin
         cnt     <= count_in;
         lane    <= off;
         pk_data <= '0;
         pk_be   <= '0;
      end else if (take) begin
         cnt <= cnt - 1'b1;
         if (wrap) begin
            lane    <= '0;
            pk_data <= '0;
            pk_be   <= '0;
         end else begin
            lane <= lane + 1'b1;
            if (dir == DIR_TO_MEM) begin
               pk_data <= push_data;
               pk_be   <= push_be;
            end
         end
      end
   end

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/funnel_wide.sv
module funnel_wide
   import funnel_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   localparam int BYTES  = WORD_W / 8,
   localparam int LANE_W = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  funnel_dir_e       dir,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  count_in,
   input  logic              fifo_full,
   input  logic              fifo_empty,
   input  logic              rd_ack,
   input  logic              wr_ack,
   output logic [ADDR_W-1:0] addr,
   output logic              rd_req,
   output logic              wr_req,
   output logic              push,
   output logic              pop
);
   logic [CNT_W-1:0]  fetch_left, span;
   logic [LANE_W-1:0] fetch_off;
   logic              step;

   assign rd_req = (dir == DIR_FROM_MEM) && (fetch_left != '0) && !fifo_full;
   assign wr_req = (dir == DIR_TO_MEM) && !fifo_empty;
   assign push   = rd_req && rd_ack;
   assign pop    = wr_req && wr_ack;
   assign step   = push || pop;
   assign span   = CNT_W'(BYTES) - CNT_W'(fetch_off);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr       <= '0;
         fetch_left <= '0;
         fetch_off  <= '0;
      end else if (load) begin
         addr       <= {start_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
         fetch_left <= (dir == DIR_FROM_MEM) ? count_in : '0;
         fetch_off  <= start_addr[LANE_W-1:0];
      end else if (step) begin
         addr <= addr + ADDR_W'(BYTES);
         if (push) begin
            fetch_left <= (fetch_left > span) ? fetch_left - span : '0;
            fetch_off  <= '0;
         end
      end
   end
endmodule

// File: rtl/funnel_dma.sv
module funnel_dma
   import funnel_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int DEPTH  = 24,
   localparam int BYTES  = WORD_W / 8,
   localparam int LANE_W = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  xfer_count,
   output logic              done,
   output logic              dreq,
   input  logic              dack,
   input  logic [7:0]        periph_rdata,
   output logic [7:0]        periph_wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_req,
   input  logic              mem_rd_ack,
   input  logic [WORD_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   input  logic              mem_wr_ack,
   output logic [WORD_W-1:0] mem_wr_data,
   output logic [BYTES-1:0]  mem_wr_be,
   input  logic              pio_rd,
   input  logic              pio_wr,
   input  logic [WORD_W-1:0] pio_wdata,
   output logic [WORD_W-1:0] pio_rdata
);
   localparam int ENT_W = WORD_W + BYTES;

   generate
      if (WORD_W % 8 != 0 || BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_width
         $error("funnel_dma: WORD_W must be a power-of-two count of bytes, at least 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("funnel_dma: DEPTH must be at least 2");
      end
      if (ADDR_W <= LANE_W || CNT_W < 2) begin : g_bad_addr
         $error("funnel_dma: ADDR_W or CNT_W too small");
      end
   endgenerate

   funnel_dir_e       dir_q;
   logic              busy, load, pio_busy;
   logic              f_push, f_pop, f_full, f_empty;
   logic [ENT_W-1:0]  f_in, f_head;
   logic              n_push, n_pop, w_push, w_pop, cnt_zero;
   logic [WORD_W-1:0] n_data;
   logic [BYTES-1:0]  n_be;
   logic [7:0]        n_byte;

   assign load     = start && !busy;
   assign pio_busy = pio_rd || pio_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         dir_q <= DIR_TO_MEM;
      end else if (load) begin
         busy  <= 1'b1;
         done  <= 1'b0;
         dir_q <= funnel_dir_e'(dir);
      end else if (busy && cnt_zero && f_empty) begin
         busy <= 1'b0;
         done <= 1'b1;
      end
   end

   funnel_narrow #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_narrow (
      .clk(clk), .rst_n(rst_n), .load(load), .dir(dir_q),
      .off(start_addr[LANE_W-1:0]), .count_in(xfer_count),
      .pio_busy(pio_busy), .dack(dack), .byte_in(periph_rdata),
      .fifo_full(f_full), .fifo_empty(f_empty), .head_data(f_head[WORD_W-1:0]),
      .push(n_push), .push_data(n_data), .push_be(n_be), .pop(n_pop),
      .dreq(dreq), .byte_out(n_byte), .cnt_zero(cnt_zero)
   );

   funnel_wide #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wide (
      .clk(clk), .rst_n(rst_n), .load(load), .dir(funnel_dir_e'(load ? dir : dir_q)),
      .start_addr(start_addr), .count_in(xfer_count),
      .fifo_full(f_full), .fifo_empty(f_empty),
      .rd_ack(mem_rd_ack), .wr_ack(mem_wr_ack), .addr(mem_addr),
      .rd_req(mem_rd_req), .wr_req(mem_wr_req), .push(w_push), .pop(w_pop)
   );

   assign f_push = (dir_q == DIR_TO_MEM) ? n_push : w_push;
   assign f_pop  = (dir_q == DIR_TO_MEM) ? w_pop  : n_pop;
   assign f_in   = (dir_q == DIR_TO_MEM) ? {n_be, n_data} : {{BYTES{1'b1}}, mem_rd_data};

   funnel_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(f_push), .push_data(f_in), .pop(f_pop),
      .head(f_head), .full(f_full), .empty(f_empty)
   );

   assign mem_wr_data  = f_head[WORD_W-1:0];
   assign mem_wr_be    = f_head[ENT_W-1:WORD_W];
   assign periph_wdata = pio_wr ? pio_wdata[7:0] : n_byte;
   assign pio_rdata    = pio_rd ? {{(WORD_W-8){1'b0}}, periph_rdata} : '0;

   // R2
   wr_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> (mem_wr_be != '0));
   // R6
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!dreq && !mem_rd_req && !mem_wr_req));
   // R9
   pio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_rd || pio_wr) |-> !dreq);
endmodule

// File: tb/funnel_dma_tb.sv
module funnel_dma_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, dir = 1'b0;
   logic [31:0] start_addr = '0;
   logic [15:0] xfer_count = '0;
   logic        done, dreq, dack = 1'b0;
   logic [7:0]  periph_rdata = '0, periph_wdata;
   logic [31:0] mem_addr, mem_rd_data = '0, mem_wr_data, pio_wdata = '0, pio_rdata;
   logic        mem_rd_req, mem_rd_ack = 1'b0, mem_wr_req, mem_wr_ack = 1'b0;
   logic [3:0]  mem_wr_be;
   logic        pio_rd = 1'b0, pio_wr = 1'b0;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   funnel_dma u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .start_addr(start_addr),
      .xfer_count(xfer_count), .done(done), .dreq(dreq), .dack(dack),
      .periph_rdata(periph_rdata), .periph_wdata(periph_wdata), .mem_addr(mem_addr),
      .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack), .mem_wr_data(mem_wr_data),
      .mem_wr_be(mem_wr_be), .pio_rd(pio_rd), .pio_wr(pio_wr), .pio_wdata(pio_wdata),
      .pio_rdata(pio_rdata)
   );

   // {dir, throttle, addr offset, stall cycles, count, pad}
   localparam int NVEC = 10;
   localparam logic [47:0] VEC [NVEC] = '{
      48'h0_1_00_00_0008_00,
      48'h0_3_01_00_0006_00,
      48'h0_2_03_00_0001_00,
      48'h0_1_02_00_0082_00,
      48'h1_1_00_00_0008_00,
      48'h1_3_02_00_0005_00,
      48'h1_2_03_00_0001_00,
      48'h1_1_01_00_0078_00,
      48'h0_1_00_96_00C8_00,
      48'h1_1_00_96_00C8_00
   };

   function automatic logic [7:0] pbyte(int seed, int k);
      return 8'(k * 5 + seed);
   endfunction

   function automatic logic [7:0] mbyte(logic [31:0] a);
      return 8'(a * 3 + 32'h11);
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic run_xfer(bit d, int thr, int off, int stall, int cnt, int seed);
      logic [31:0] base = 32'h100 + 32'(off);
      int idx = 0, nwr = 0, nrd = 0, cyc = 0;
      int nw = (cnt == 0) ? 0 : (off + cnt + 3) / 4;
      @(negedge clk);
      dir = d; start_addr = base; xfer_count = 16'(cnt); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 3000) begin
         bit go, wgo, pgo;
         cyc++;
         go  = (cyc % thr) == 0;
         wgo = go && !(d == 1'b0 && cyc <= stall);
         pgo = go && !(d == 1'b1 && cyc <= stall);
         if (stall != 0 && cyc == stall) begin
            // R4: fill limits while one side is stalled
            if (d == 1'b0) chk(idx == 96, "R4 bytes accepted while memory stalled", 32'(idx), 96);
            else           chk(nrd == 24, "R4 words fetched while peripheral stalled", 32'(nrd), 24);
         end
         start = (stall != 0 && cyc == stall / 2);
         if (start) begin
            // R7: restart while busy
            dir = ~d; xfer_count = 16'd3; start_addr = 32'h203;
         end
         dack = dreq && pgo;
         periph_rdata = pbyte(seed, idx);
         if (dack) begin
            if (d == 1'b1)
               chk(periph_wdata == mbyte(base + 32'(idx)), "R3 byte order",
                   32'(periph_wdata), 32'(mbyte(base + 32'(idx))));
            idx++;
         end
         mem_wr_ack = mem_wr_req && wgo;
         if (mem_wr_ack) begin
            logic [3:0]  ebe = '0;
            logic [31:0] edat = '0;
            for (int l = 0; l < 4; l++) begin
               logic [31:0] a = mem_addr + 32'(l);
               if (a >= base && a < base + 32'(cnt)) begin
                  ebe[l] = 1'b1;
                  edat[l*8 +: 8] = pbyte(seed, int'(a - base));
               end
            end
            chk(mem_wr_be == ebe && (mem_wr_data & {{8{ebe[3]}}, {8{ebe[2]}}, {8{ebe[1]}}, {8{ebe[0]}}}) == edat
                && mem_addr == ((base & ~32'h3) + 32'(4 * nwr)),
                "R2 packed word", mem_wr_data, edat);
            nwr++;
         end
         mem_rd_ack = mem_rd_req && wgo;
         mem_rd_data = '0;
         if (mem_rd_ack) begin
            for (int l = 0; l < 4; l++) mem_rd_data[l*8 +: 8] = mbyte(mem_addr + 32'(l));
            nrd++;
         end
         @(negedge clk);
         start = 1'b0;
      end
      dack = 1'b0; mem_wr_ack = 1'b0; mem_rd_ack = 1'b0;
      // R5 and R6: exact byte count, completion held
      chk(idx == cnt, "R5 bytes exchanged", 32'(idx), 32'(cnt));
      chk(done == 1'b1 && dreq == 1'b0, "R6 done after drain", {31'b0, done}, 1);
      if (d == 1'b0) chk(nwr == nw, "R2 word writes", 32'(nwr), 32'(nw));
      else           chk(nrd == nw, "R3 word fetches", 32'(nrd), 32'(nw));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!dreq && !mem_rd_req && !mem_wr_req && !done && pio_rdata == 0, "R1 in reset",
          {28'b0, dreq, mem_rd_req, mem_wr_req, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!dreq && !mem_rd_req && !mem_wr_req && !done, "R1 after reset",
          {28'b0, dreq, mem_rd_req, mem_wr_req, done}, 0);

      // R8: PIO read bypass
      periph_rdata = 8'hA5; pio_rd = 1'b1;
      @(negedge clk);
      chk(pio_rdata == 32'h0000_00A5, "R8 pio read lane 0", pio_rdata, 32'hA5);
      pio_rd = 1'b0;
      @(negedge clk);
      chk(pio_rdata == 32'h0, "R8 pio idle", pio_rdata, 0);

      // R9: PIO write bypass
      pio_wdata = 32'h1234_56C3; pio_wr = 1'b1;
      @(negedge clk);
      chk(periph_wdata == 8'hC3, "R9 pio write lane 0", 32'(periph_wdata), 32'hC3);
      pio_wr = 1'b0;

      for (int v = 0; v < NVEC; v++) begin
         logic [47:0] e = VEC[v];
         run_xfer(e[44], int'(e[43:40]), int'(e[39:32]), int'(e[31:24]), int'(e[23:8]), v * 16 + 1);
      end

      // R6: zero count completes with no request
      @(negedge clk);
      dir = 1'b0; start_addr = 32'h100; xfer_count = 16'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0, "R6 done clears on start", {31'b0, done}, 0);
      @(negedge clk);
      chk(done == 1'b1 && !dreq && !mem_rd_req, "R6 zero count done", {31'b0, done}, 1);

      // R9: PIO strobe holds off dreq mid-transfer
      dir = 1'b0; xfer_count = 16'd4; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk(dreq == 1'b1, "R5 dreq with count", {31'b0, dreq}, 1);
      pio_rd = 1'b1;
      #1;
      chk(dreq == 1'b0, "R9 dreq held during pio", {31'b0, dreq}, 0);
      pio_rd = 1'b0;
      for (int i = 0; i < 12 && !done; i++) begin
         dack = dreq; mem_wr_ack = mem_wr_req;
         @(negedge clk);
      end
      dack = 1'b0; mem_wr_ack = 1'b0;
      chk(done == 1'b1, "R6 done after pio pause", {31'b0, done}, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule